// File: doc/BRIEF.md
# Level-Sensitive Two-Line Interrupt Controller

This block gathers 32 level-sensitive interrupt request inputs and presents them to a processor on two interrupt lines. Software controls the block through a small word-wide register port with separate read and write strobes. Each source has one enable bit. A write-one-to-set word turns enables on, and a write-one-to-clear word turns them off, so no read-modify-write is needed. A per-source steering bit sends each source to line 0 or line 1. Each line has a pending word that software reads to find which enabled sources are requesting. Software is expected to service the lowest-numbered pending bit first.

The top enable bit (bit 31) is also a master switch: neither line can assert while it is clear. The request inputs are asynchronous to the block's clock, so they pass through a synchronizer before they reach the level word and the routing logic. Because the sources are level-sensitive, there is nothing to acknowledge inside the block. A pending bit falls only when its source input falls.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, every enable bit (including bit 31) and every steering bit is 0, both interrupt lines are low, and the read data is 0.
- R2: A write to byte offset 0x34 sets each enable bit whose write-data bit is 1; enable bits written with 0 keep their value.
- R3: A write to byte offset 0x38 clears each enable bit whose write-data bit is 1; enable bits written with 0 keep their value.
- R4: Enable bit 31 gates both lines: while it is 0, both irq_out0 and irq_out1 are low, whatever the sources and other enables are.
- R5: Offset 0x20 holds the steering word and is read/write. Steering bit i = 0 sends source i to line 0, and steering bit i = 1 sends it to line 1.
- R6: Offset 0x00 reads level AND enable AND NOT steering (line 0 pending), and offset 0x04 reads level AND enable AND steering (line 1 pending). Bit i is source i. The master bit does not mask these words.
- R7: irq_out0 equals the OR of the line 0 pending word gated by bit 31, and irq_out1 equals the same for line 1. Each line changes in the cycle after the state it depends on is updated.
- R8: Offset 0x30 reads the unmasked source levels after a synchronizer of SYNC_STAGES flops (2 by default). A source change driven before clock edge k appears after edge k+1.
- R9: A pending bit stays set as long as its source input stays high, whatever register reads take place. It clears only when the input falls, after the synchronizer latency.
- R10: A read strobe loads bus_rdata on the next clock edge, and bus_rdata holds its value until the next read. Offsets 0x34 and 0x38 both read the current enable word, and any unmapped offset reads 0.
- R11: Writes to offsets 0x00, 0x04, 0x30 and to unmapped offsets change no enable or steering bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 32 | Asynchronous level request inputs, bit i is source i |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_out0 | output | 1 | Interrupt line 0 |
| irq_out1 | output | 1 | Interrupt line 1 |

## Verification
The enable and steering words are the only state besides the synchronizer. A wrong bit in either shows on an interrupt line one cycle after the write that caused it, and on the matching pending word at the next read. The bench therefore compares both lines against a behavioural model on every clock, so a corrupted enable, a wrong steering bit or a dropped master gate is caught within a cycle. A synchronizer with the wrong depth shows as a one-cycle shift in when a line rises or falls after a source edge, and that per-cycle comparison catches it too.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned OFS_W  = 8;
  localparam int unsigned N_LINE = 2;

  // register byte offsets
  typedef enum logic [OFS_W-1:0] {
    OFS_PEND0 = 8'h00,
    OFS_PEND1 = 8'h04,
    OFS_STEER = 8'h20,
    OFS_LEVEL = 8'h30,
    OFS_ENSET = 8'h34,
    OFS_ENCLR = 8'h38
  } reg_ofs_e;

  typedef logic [WORD_W-1:0] word_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctl_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [N_SRC-1:0] wr_data,
  output logic [N_SRC-1:0] en_q,
  output logic [N_SRC-1:0] steer_q,
  output logic             master_en
);

  localparam int unsigned MASTER_BIT = N_SRC - 1;

  logic hit_set, hit_clr, hit_steer;

  always_comb begin
    hit_set   = wr_stb && (wr_ofs == OFS_ENSET);
    hit_clr   = wr_stb && (wr_ofs == OFS_ENCLR);
    hit_steer = wr_stb && (wr_ofs == OFS_STEER);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      steer_q <= '0;
    end else begin
      if (hit_set)   en_q    <= en_q | wr_data;
      if (hit_clr)   en_q    <= en_q & ~wr_data;
      if (hit_steer) steer_q <= wr_data;
    end
  end

  assign master_en = en_q[MASTER_BIT];

  // R2: every written one is set afterwards
  a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    hit_set |=> ((en_q & $past(wr_data)) == $past(wr_data)));
  // R3: every written one is cleared afterwards
  a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    hit_clr |=> ((en_q & $past(wr_data)) == '0));
  // R11: other offsets leave the enables untouched
  a_r11_en_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_set || hit_clr) |=> $stable(en_q));
  // R5: steering only moves on its own offset
  a_r5_steer_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_steer |=> $stable(steer_q));

endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_ctl_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_SRC-1:0]             level,
  input  logic [N_SRC-1:0]             en,
  input  logic [N_SRC-1:0]             steer,
  input  logic                         master_en,
  output logic [N_LINE-1:0][N_SRC-1:0] pend,
  output logic [N_LINE-1:0]            line
);

  for (genvar o = 0; o < N_LINE; o++) begin : g_line
    logic [N_SRC-1:0] sel;
    if (o == 0) begin : g_l0
      assign sel = ~steer;
    end else begin : g_l1
      assign sel = steer;
    end
    assign pend[o] = level & en & sel;
    assign line[o] = master_en & (|pend[o]);
  end

  // R6: a source never pends on both lines
  a_r6_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] & pend[1]) == '0);

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] src_lvl,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq_out0,
  output logic              irq_out1
);

  localparam int unsigned N_SRC = WORD_W;

  word_t                         level, en, steer;
  logic                          master_en;
  logic [N_LINE-1:0][N_SRC-1:0] pend;
  logic [N_LINE-1:0]             line;
  word_t                         rd_mux;

  irq_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_lvl), .q(level)
  );

  irq_regs #(.N_SRC(N_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(bus_wr), .wr_ofs(bus_addr),
    .wr_data(bus_wdata), .en_q(en), .steer_q(steer), .master_en(master_en)
  );

  irq_route #(.N_SRC(N_SRC)) u_route (
    .clk(clk), .rst_n(rst_n), .level(level), .en(en), .steer(steer),
    .master_en(master_en), .pend(pend), .line(line)
  );

  always_comb begin
    case (bus_addr)
      OFS_PEND0: rd_mux = pend[0];
      OFS_PEND1: rd_mux = pend[1];
      OFS_STEER: rd_mux = steer;
      OFS_LEVEL: rd_mux = level;
      OFS_ENSET,
      OFS_ENCLR: rd_mux = en;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign irq_out0 = line[0];
  assign irq_out1 = line[1];

  // R4: master bit gates both lines
  a_r4_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> (!irq_out0 && !irq_out1));
  // R10: read data holds between reads
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  // R7: a line only rises with a pending source on it
  a_r7_line_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out1 |-> ((level & en & steer) != '0));

endmodule

// File: tb/test_lvl_irq_ctrl.sv
module test_lvl_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lvl = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out0, irq_out1;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;

  always #5 clk = ~clk;

  lvl_irq_ctrl i_lvl_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out0(irq_out0), .irq_out1(irq_out1)
  );

  // behavioural reference
  logic [31:0] m_en = '0, m_steer = '0;
  logic [31:0] m_seen[$] = '{32'h0, 32'h0};

  function automatic logic [31:0] m_level();
    return m_seen[0];
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_level() & m_en & ~m_steer;
      8'h04: return m_level() & m_en & m_steer;
      8'h20: return m_steer;
      8'h30: return m_level();
      8'h34, 8'h38: return m_en;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en <= '0; m_steer <= '0; m_seen = '{32'h0, 32'h0};
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          8'h34: m_en <= m_en | bus_wdata;
          8'h38: m_en <= m_en & ~bus_wdata;
          8'h20: m_steer <= bus_wdata;
          default: ;
        endcase
      end
      void'(m_seen.pop_front());
      m_seen.push_back(src_lvl);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R7: lines compared with the model on every clock
  always @(negedge clk) begin
    if (running) begin
      check("R7 irq_out0", {31'h0, irq_out0},
            {31'h0, m_en[31] & (|(m_level() & m_en & ~m_steer))});
      check("R7 irq_out1", {31'h0, irq_out1},
            {31'h0, m_en[31] & (|(m_level() & m_en & m_steer))});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] lit);
    logic [31:0] exp;
    @(negedge clk);
    exp = m_read(a);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, exp);
    check({req, " literal"}, bus_rdata, lit);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    check("R1 irq_out0 in reset", {31'h0, irq_out0}, 32'h0);
    check("R1 rdata in reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    running = 1'b1;
    rd("R1 enables after reset", 8'h34, 32'h0);
    rd("R1 steering after reset", 8'h20, 32'h0);

    wr(8'h34, 32'h0000_00F0);
    wr(8'h38, 32'hFFFF_FFFF);
    rd("R3 clear all", 8'h34, 32'h0);

    src_lvl = 32'h0000_0020;
    idle(3);
    rd("R8 level unmasked", 8'h30, 32'h0000_0020);
    rd("R6 pend0 while disabled", 8'h00, 32'h0);

    wr(8'h34, 32'h0000_0020);
    check("R4 no line without master", {31'h0, irq_out0}, 32'h0);
    wr(8'h34, 32'h8000_0000);
    check("R7 line0 rises", {31'h0, irq_out0}, 32'h1);
    rd("R6 pend0 source 5", 8'h00, 32'h0000_0020);
    wr(8'h34, 32'h0000_0001);
    rd("R2 zeros keep bits", 8'h34, 32'h8000_0021);
    rd("R9 pending held after reads", 8'h00, 32'h0000_0020);
    check("R9 line held", {31'h0, irq_out0}, 32'h1);

    src_lvl = 32'h0;
    @(negedge clk);
    check("R8 line before latency", {31'h0, irq_out0}, 32'h1);
    @(negedge clk);
    check("R9 line drops with input", {31'h0, irq_out0}, 32'h0);
    rd("R9 pend cleared", 8'h00, 32'h0);

    wr(8'h20, 32'h0000_0020);
    rd("R5 steering readback", 8'h20, 32'h0000_0020);
    src_lvl = 32'h0000_0020;
    idle(3);
    check("R5 routed to line1", {31'h0, irq_out1}, 32'h1);
    check("R5 line0 quiet", {31'h0, irq_out0}, 32'h0);
    rd("R6 pend1 source 5", 8'h04, 32'h0000_0020);

    wr(8'h38, 32'h8000_0000);
    check("R4 master off drops line1", {31'h0, irq_out1}, 32'h0);
    rd("R6 pend1 not master gated", 8'h04, 32'h0000_0020);
    wr(8'h34, 32'h8000_0000);

    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'h0000_0000);
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    rd("R11 enables kept", 8'h34, 32'h8000_0021);
    rd("R11 steering kept", 8'h20, 32'h0000_0020);
    rd("R10 unmapped reads zero", 8'h10, 32'h0);
    rd("R10 clear offset reads mask", 8'h38, 32'h8000_0021);

    src_lvl = 32'h0000_0F21;
    wr(8'h34, 32'h0000_0300);
    wr(8'h20, 32'h0000_0200);
    idle(2);
    rd("R6 pend0 mixed", 8'h00, 32'h0000_0121);
    rd("R6 pend1 mixed", 8'h04, 32'h0000_0200);
    rd("R8 level mixed", 8'h30, 32'h0000_0F21);

    idle(4);
    check("R10 rdata held", bus_rdata, 32'h0000_0F21);
    running = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule